// File: doc/BRIEF.md
# Serial Private-Scalar Generator

This block builds a private scalar for an elliptic-curve key agreement one bit at a time. A 32-bit shift register with linear feedback steps once per clock. Each feedback bit it produces is appended to a KEY_W-bit accumulator. Once KEY_W bits have been collected, the accumulator is checked against the legal scalar range, which runs from 1 up to one less than the group order given as the `ORDER` parameter. A legal value is published on the key output and the done flag is raised. An illegal value is discarded and a fresh batch of KEY_W bits is collected.

Software or a neighbouring controller loads a seed when it wants to, then pulses start. With the default 163-bit width and a first batch that passes the check, the result arrives 164 cycles after the start edge. The published key is held until a later generation completes. While a generation is running, further start pulses are ignored. A seed load takes precedence over a start in the same cycle.

Top module: `scalar_keygen`

## Requirements
- R1: After reset, `key` is all zeros, `done` is 0, and the shift register holds the constant 32'hACE12D5B.
- R2: One step computes feedback bit f as the XOR of state bits 31, 27, 18, 17, 15, 13, 10, 9, 8, 5, 4 and 0. This implements x^32+x^28+x^19+x^18+x^16+x^14+x^11+x^10+x^9+x^6+x^5+x+1. The new state is {state[30:0], f}. The accumulator becomes {acc[KEY_W-2:0], f}, so the first bit of a batch ends up in the MSB of the key.
- R3: When `seedLoad` is high, the shift register takes `seedValue`. If `seedValue` is zero, the register takes 32'hACE12D5B instead.
- R4: When the first batch is legal, `done` goes high after the (KEY_W+1)-th rising edge counted from the edge that accepted start. That is one cycle after the last bit of the batch is shifted in.
- R5: A batch equal to zero, or not less than `ORDER`, is discarded and a new batch is collected. Each attempt takes KEY_W+1 cycles, and only a legal value is ever published.
- R6: `key` changes only at the edge where `done` rises. Between those edges it holds its value, including during a later generation.
- R7: A start pulse while a generation is in progress, including during its range-check cycle, has no effect on the result or on its timing.
- R8: When `seedLoad` and `start` are both high in an idle cycle, the seed is loaded and no generation begins. `done` and `key` keep their values.
- R9: An accepted start clears `done` at the edge that accepts it. The shift register does not step while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load `seedValue` into the shift register |
| seedValue | input | 32 | Seed; zero is replaced by a fixed constant |
| start | input | 1 | Begin a generation when idle |
| key | output | KEY_W | Last published private scalar |
| done | output | 1 | A published scalar is available |

## Verification
The bench builds the block with KEY_W = 8 and ORDER = 100. At this size roughly six batches in ten are rejected, and all-zero batches also occur within a few hundred runs, so the regeneration path and its multiple-of-nine latency are exercised many times. The bench keeps its own model of the shift register, so the expected key and cycle count for each run come from R2 and R5 alone. Busy-start and simultaneous seed/start cases are placed at chosen cycles, including the range-check cycle.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  // taps for x^32+x^28+x^19+x^18+x^16+x^14+x^11+x^10+x^9+x^6+x^5+x+1
  localparam logic [31:0] FB_MASK   = 32'h8806_A731;
  localparam logic [31:0] SAFE_SEED = 32'hACE1_2D5B;

  typedef struct packed {
    logic seedWr;
    logic shiftEn;
    logic commit;
  } kg_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CHECK
  } kg_state_e;
endpackage

// File: rtl/keygen_ctrl.sv
module keygen_ctrl
  import keygen_pkg::*;
#(
  parameter int KEY_W = 163
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     seedLoad,
  input  logic     start,
  input  logic     keyOk,
  output kg_ctrl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(KEY_W - 1);

  kg_state_e stateQ;
  logic [CNT_W-1:0] bitCnt;
  logic doneQ;

  always_comb begin
    ctl.seedWr  = seedLoad;
    ctl.shiftEn = (stateQ == ST_SHIFT);
    ctl.commit  = (stateQ == ST_CHECK) && keyOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (start && !seedLoad) begin
            stateQ <= ST_SHIFT;
            bitCnt <= '0;
            doneQ  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (bitCnt == LAST_BIT) begin
            stateQ <= ST_CHECK;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_CHECK: begin
          bitCnt <= '0;
          if (keyOk) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end else begin
            stateQ <= ST_SHIFT;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/keygen_dp.sv
module keygen_dp
  import keygen_pkg::*;
#(
  parameter int KEY_W = 163,
  parameter logic [KEY_W-1:0] ORDER = {1'b0, {(KEY_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  kg_ctrl_t         ctl,
  input  logic [31:0]      seedValue,
  output logic [KEY_W-1:0] key,
  output logic             keyOk
);
  logic [31:0]      lfsrQ;
  logic [KEY_W-1:0] accQ;
  logic [KEY_W-1:0] accNext;
  logic [KEY_W-1:0] keyQ;
  logic             fbBit;
  logic [31:0]      seedSafe;

  assign fbBit    = ^(lfsrQ & FB_MASK);
  assign seedSafe = (seedValue == 32'd0) ? SAFE_SEED : seedValue;

  generate
    if (KEY_W == 1) begin : g_single
      assign accNext = fbBit;
    end else begin : g_wide
      assign accNext = {accQ[KEY_W-2:0], fbBit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= SAFE_SEED;
      accQ  <= '0;
      keyQ  <= '0;
    end else begin
      if (ctl.seedWr) begin
        lfsrQ <= seedSafe;
      end else if (ctl.shiftEn) begin
        lfsrQ <= {lfsrQ[30:0], fbBit};
      end
      if (ctl.shiftEn) begin
        accQ <= accNext;
      end
      if (ctl.commit) begin
        keyQ <= accQ;
      end
    end
  end

  assign keyOk = (accQ != '0) && (accQ < ORDER);
  assign key   = keyQ;
endmodule

// File: rtl/scalar_keygen.sv
module scalar_keygen
  import keygen_pkg::*;
#(
  parameter int KEY_W = 163,
  parameter logic [KEY_W-1:0] ORDER = {1'b0, {(KEY_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic [31:0]      seedValue,
  input  logic             start,
  output logic [KEY_W-1:0] key,
  output logic             done
);
  kg_ctrl_t ctl;
  logic keyOk;
  logic busy;

  keygen_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .start(start),
    .keyOk(keyOk), .ctl(ctl), .busy(busy), .done(done)
  );

  keygen_dp #(.KEY_W(KEY_W), .ORDER(ORDER)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seedValue(seedValue),
    .key(key), .keyOk(keyOk)
  );
endmodule

// File: rtl/keygen_chk.sv
module keygen_chk #(
  parameter int KEY_W = 163,
  parameter logic [KEY_W-1:0] ORDER = {1'b0, {(KEY_W-1){1'b1}}}
) (
  input logic             clk,
  input logic             rstN,
  input logic             seedLoad,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [KEY_W-1:0] key
);
  // R6
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> $stable(key));

  // R5
  key_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (key != '0) && (key < ORDER));

  // R4
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !seedLoad && !busy) |=> (busy && !done));

  // R8
  seed_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && start && !busy) |=> (!busy && $stable(done)));
endmodule

bind scalar_keygen keygen_chk #(.KEY_W(KEY_W), .ORDER(ORDER)) u_chk (
  .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .start(start),
  .busy(busy), .done(done), .key(key)
);

// File: tb/scalar_keygen_tb.sv
module scalar_keygen_tb;
  localparam int KW = 8;
  localparam logic [KW-1:0] ORD = 8'd100;
  localparam logic [31:0] MASK = 32'h8806_A731;
  localparam logic [31:0] SAFE = 32'hACE1_2D5B;

  logic clk = 1'b0;
  logic rstN;
  logic seedLoad;
  logic [31:0] seedValue;
  logic start;
  logic [KW-1:0] key;
  logic done;

  int nChk = 0;
  int nBad = 0;
  logic [31:0] mSt;
  logic [KW-1:0] prevKey;

  always #10 clk = ~clk;

  scalar_keygen #(.KEY_W(KW), .ORDER(ORD)) u_dut (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedValue(seedValue),
    .start(start), .key(key), .done(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic stepM(inout logic [31:0] s);
    logic f;
    f = ^(s & MASK);
    s = {s[30:0], f};
    return f;
  endfunction

  task automatic predict(output logic [KW-1:0] k, output int att);
    logic [KW-1:0] a;
    att = 0;
    do begin
      att++;
      a = '0;
      for (int i = 0; i < KW; i++) a = {a[KW-2:0], stepM(mSt)};
    end while (a == '0 || a >= ORD);
    k = a;
  endtask

  task automatic loadSeed(input logic [31:0] v);
    @(negedge clk);
    seedLoad = 1'b1; seedValue = v;
    @(negedge clk);
    seedLoad = 1'b0;
    mSt = (v == 32'd0) ? SAFE : v;  // R3
  endtask

  // one generation; poke1/poke2 = cycle numbers at which a stray start is driven
  task automatic runOnce(input string tag, input int poke1, input int poke2);
    logic [KW-1:0] expK;
    int att, n;
    bit moved;
    predict(expK, att);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 done cleared"}, 64'(done), 64'd0);
    n = 0;
    moved = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      start = (n == poke1 || n == poke2);
      if (done) begin
        start = 1'b0;
        break;
      end
      if (key !== prevKey) moved = 1;
    end
    check({tag, " R6 key held while busy"}, 64'(moved), 64'd0);
    check({tag, " R4/R5 latency"}, 64'(n), 64'(att * (KW + 1)));
    check({tag, " R2 key value"}, 64'(key), 64'(expK));
    prevKey = key;
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 key after reset", 64'(key), 64'd0);
    check("R1 done after reset", 64'(done), 64'd0);
    repeat (5) @(negedge clk);
    check("R9 idle holds key", 64'(key), 64'd0);
  endtask

  task automatic tSeedPriority(input logic [31:0] v);
    logic [KW-1:0] held;
    held = key;
    @(negedge clk);
    seedLoad = 1'b1; start = 1'b1; seedValue = v;
    @(negedge clk);
    seedLoad = 1'b0; start = 1'b0;
    mSt = (v == 32'd0) ? SAFE : v;
    repeat (2 * (KW + 1)) @(negedge clk);
    check("R8 done kept", 64'(done), 64'd1);
    check("R8 key kept", 64'(key), 64'(held));
    runOnce("R8 seed taken", -1, -1);
  endtask

  initial begin
    rstN = 1'b0; seedLoad = 1'b0; seedValue = '0; start = 1'b0;
    mSt = SAFE;  // R1 reset state
    prevKey = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    runOnce("R1 reset seed", -1, -1);
    runOnce("R2 continued", -1, -1);
    loadSeed(32'h1234_5678);
    runOnce("R3 loaded seed", -1, -1);
    loadSeed(32'd0);
    runOnce("R3 zero seed", -1, -1);
    runOnce("R7 busy start", 3, KW);
    runOnce("R7 busy start late", 1, KW + 1);
    tSeedPriority(32'hDEAD_BEEF);
    for (int s = 0; s < 40; s++) begin
      if (s % 8 == 0) loadSeed(32'h0F0F_0000 + 32'(s * 977));
      runOnce("R5 sweep", -1, -1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule